// File: doc/BRIEF.md
# Resistive memory cell pulse sequencer

This block drives the programming of one selected resistive memory cell. It can run three operations: forming, which creates the initial filament in a fresh cell; SET, which lowers the resistance; and RESET, which raises it. The block does not produce analog voltages. It presents 6-bit codes, in units of 0.1 V, for the wordline, the bitline and the source line to external DACs. It also raises a pulse-enable strobe while the cell is under stress.

After each pulse, the block asks an external read comparator whether the cell has reached its target state. The search is two-dimensional. The wordline level rises by one step after each failed verify. When the wordline range is used up, the wordline returns to its first level and the driven line (bitline or source line) moves up one step.

An operation ends at the first verify that reports success, or when both ranges are used up. The block then reports a one-cycle done strobe, a pass flag and the number of pulses spent. Ranges, the wordline floor and the pulse width come either from built-in defaults for each operation or from configuration inputs. These are captured when the operation starts.

Top module: `rram_pulse_seq`

## Requirements
- R1: Out of reset, and whenever no operation is running, all three line codes are 0, and pulse_en, vfy_req, busy and done are low.
- R2: The operation is selected by op: 2'b00 forming, 2'b01 SET, 2'b10 RESET. Forming and SET put the level on bl_code and hold sl_code at 0. RESET puts it on sl_code and holds bl_code at 0.
- R3: With use_cfg low, the built-in settings apply:
  - forming: wordline 14..25, bitline 24..33
  - SET: wordline 17, bitline 24
  - RESET: wordline 25, source line 26
  - wordline floor: 5
  - pulse width: 1000 ns, which is 200 clock cycles at a 5 ns clock.
- R4: After a failed verify, the wordline code rises by 1 if it is below its last level. Otherwise the wordline returns to its first level and the driven line rises by 1.
- R5: pulse_en stays high for exactly the programmed number of clock cycles. A programmed width of 0 gives 1 cycle.
- R6: Each pulse is preceded and followed by at least one cycle with pulse_en low and the line codes already at their pulse values. No line code changes while pulse_en is high.
- R7: After each pulse and its settle cycle, vfy_req is held high until vfy_valid arrives. A verify with vfy_pass high ends the operation: done goes high for one cycle, pass is 1, and pulse_cnt equals the number of pulses issued.
- R8: A failed verify at the last wordline level and the last driven-line level ends the operation with pass 0 and pulse_cnt equal to the full search size. All line codes then return to 0.
- R9: During a pulse, wl_code is the larger of the current wordline level and the wordline floor.
- R10: start is ignored while busy is high. A start with op equal to 2'b11 is ignored and starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (one-cycle strobe) |
| op | input | 2 | Operation: 00 form, 01 set, 10 reset |
| use_cfg | input | 1 | 1: use cfg_* inputs; 0: built-in settings |
| cfg_wl_first | input | 6 | First wordline level |
| cfg_wl_last | input | 6 | Last wordline level |
| cfg_drv_first | input | 6 | First bitline/source line level |
| cfg_drv_last | input | 6 | Last bitline/source line level |
| cfg_wl_floor | input | 6 | Minimum wordline code during pulses |
| cfg_pulse_cyc | input | 16 | Pulse width in clock cycles |
| vfy_valid | input | 1 | Verify result valid |
| vfy_pass | input | 1 | Cell reached target state |
| wl_code | output | 6 | Wordline DAC code |
| bl_code | output | 6 | Bitline DAC code |
| sl_code | output | 6 | Source line DAC code |
| pulse_en | output | 1 | Programming pulse active |
| vfy_req | output | 1 | Verify request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| pass | output | 1 | Result of the last operation |
| pulse_cnt | output | 13 | Pulses used by the last operation |

## Verification
The search is tried in several ways:
- Operations that pass on the first pulse show which line is driven and the per-operation defaults.
- A small two-by-three range that passes on its fifth pulse separates inner wordline stepping from the outer driven-line step and the wordline wrap.
- Forming with defaults that passes on pulse thirteen checks the wrap at the real range edge.
- Never-passing runs tell a proper exhaustion count from an early or late stop.
- Ranges set below the floor show whether the floor clamps the wordline.
- Pulse widths of 0, 1, 2, 4 and 200 cycles, a delayed verify response, and start strobes given while busy or with the unused op code separate correct timing from off-by-one and re-trigger faults.

// File: rtl/rps_pkg.sv
package rps_pkg;

  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    OP_FORM  = 2'b00,
    OP_SET   = 2'b01,
    OP_RESET = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_PULSE,
    S_POST,
    S_VFY,
    S_DONE
  } st_e;

  typedef struct packed {
    logic [CODE_W-1:0] wl_first;
    logic [CODE_W-1:0] wl_last;
    logic [CODE_W-1:0] drv_first;
    logic [CODE_W-1:0] drv_last;
    logic [CODE_W-1:0] wl_floor;
  } range_t;

  // built-in levels, in 0.1 V units
  localparam logic [CODE_W-1:0] FORM_WL_LO  = 6'd14;
  localparam logic [CODE_W-1:0] FORM_WL_HI  = 6'd25;
  localparam logic [CODE_W-1:0] FORM_BL_LO  = 6'd24;
  localparam logic [CODE_W-1:0] FORM_BL_HI  = 6'd33;
  localparam logic [CODE_W-1:0] SET_WL      = 6'd17;
  localparam logic [CODE_W-1:0] SET_BL      = 6'd24;
  localparam logic [CODE_W-1:0] RST_WL      = 6'd25;
  localparam logic [CODE_W-1:0] RST_SL      = 6'd26;
  localparam logic [CODE_W-1:0] WL_FLOOR_DF = 6'd5;

  function automatic range_t builtin_range(input op_e op);
    range_t r;
    r.wl_floor = WL_FLOOR_DF;
    case (op)
      OP_FORM: begin
        r.wl_first = FORM_WL_LO; r.wl_last = FORM_WL_HI;
        r.drv_first = FORM_BL_LO; r.drv_last = FORM_BL_HI;
      end
      OP_SET: begin
        r.wl_first = SET_WL; r.wl_last = SET_WL;
        r.drv_first = SET_BL; r.drv_last = SET_BL;
      end
      default: begin
        r.wl_first = RST_WL; r.wl_last = RST_WL;
        r.drv_first = RST_SL; r.drv_last = RST_SL;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rps_search.sv
module rps_search #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [CODE_W-1:0] wl_first,
  input  logic [CODE_W-1:0] wl_last,
  input  logic [CODE_W-1:0] drv_first,
  input  logic [CODE_W-1:0] drv_last,
  output logic [CODE_W-1:0] wl_lvl,
  output logic [CODE_W-1:0] drv_lvl,
  output logic              exhausted
);

  logic [CODE_W-1:0] wl_q, wl_d, drv_q, drv_d;
  logic [CODE_W-1:0] wl_first_q, wl_last_q, drv_last_q;
  logic              inner_end, outer_end, lvl_en;

  assign inner_end = (wl_q >= wl_last_q);
  assign outer_end = (drv_q >= drv_last_q);
  assign exhausted = inner_end && outer_end;
  assign lvl_en    = load || advance;

  always_comb begin
    wl_d  = wl_q;
    drv_d = drv_q;
    if (load) begin
      wl_d  = wl_first;
      drv_d = drv_first;
    end else if (advance) begin
      if (!inner_end) begin
        wl_d = wl_q + 1'b1;
      end else begin
        wl_d  = wl_first_q;
        drv_d = drv_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q       <= '0;
      drv_q      <= '0;
      wl_first_q <= '0;
      wl_last_q  <= '0;
      drv_last_q <= '0;
    end else begin
      if (lvl_en) begin
        wl_q  <= wl_d;
        drv_q <= drv_d;
      end
      if (load) begin
        wl_first_q <= wl_first;
        wl_last_q  <= wl_last;
        drv_last_q <= drv_last;
      end
    end
  end

  assign wl_lvl  = wl_q;
  assign drv_lvl = drv_q;

  // R8: the search never steps beyond its final point
  p_no_step_past_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !exhausted);

  // R4: an outer step puts the wordline back at its first level
  p_wrap_wordline_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && inner_end) |=> (wl_q == wl_first_q));

endmodule

// File: rtl/rps_timer.sv
module rps_timer #(
  parameter int PW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            run,
  input  logic [PW_W-1:0] width,
  output logic            last
);

  logic [PW_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign last   = (cnt_q == {{(PW_W-1){1'b0}}, 1'b1});
  assign cnt_en = load || (run && !last);

  always_comb begin
    if (load) cnt_d = (width == '0) ? {{(PW_W-1){1'b0}}, 1'b1} : width;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: a running pulse always has cycles left to count
  p_run_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));

endmodule

// File: rtl/rram_pulse_seq.sv
module rram_pulse_seq
  import rps_pkg::*;
#(
  parameter int PW_W     = 16,
  parameter int CLK_PS   = 5000,
  parameter int PULSE_NS = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic                use_cfg,
  input  logic [CODE_W-1:0]   cfg_wl_first,
  input  logic [CODE_W-1:0]   cfg_wl_last,
  input  logic [CODE_W-1:0]   cfg_drv_first,
  input  logic [CODE_W-1:0]   cfg_drv_last,
  input  logic [CODE_W-1:0]   cfg_wl_floor,
  input  logic [PW_W-1:0]     cfg_pulse_cyc,
  input  logic                vfy_valid,
  input  logic                vfy_pass,
  output logic [CODE_W-1:0]   wl_code,
  output logic [CODE_W-1:0]   bl_code,
  output logic [CODE_W-1:0]   sl_code,
  output logic                pulse_en,
  output logic                vfy_req,
  output logic                busy,
  output logic                done,
  output logic                pass,
  output logic [2*CODE_W:0]   pulse_cnt
);

  localparam int CNT_W = 2*CODE_W + 1;
  localparam logic [PW_W-1:0] PW_DEF = PW_W'((PULSE_NS * 1000) / CLK_PS);

  st_e               st_q, st_d;
  op_e               op_q;
  logic [CODE_W-1:0] floor_q;
  logic [PW_W-1:0]   pw_q;
  logic              pass_q;
  logic [CNT_W-1:0]  cnt_q;

  range_t            sel_rng;
  logic [PW_W-1:0]   sel_pw;
  logic              start_ok, vfy_fail, step, active;
  logic [CODE_W-1:0] wl_lvl, drv_lvl, wl_eff;
  logic              exhausted, t_last;

  assign start_ok = start && (st_q == S_IDLE) && (op != OP_NONE);
  assign vfy_fail = (st_q == S_VFY) && vfy_valid && !vfy_pass;
  assign step     = vfy_fail && !exhausted;

  always_comb begin
    if (use_cfg) begin
      sel_rng.wl_first  = cfg_wl_first;
      sel_rng.wl_last   = cfg_wl_last;
      sel_rng.drv_first = cfg_drv_first;
      sel_rng.drv_last  = cfg_drv_last;
      sel_rng.wl_floor  = cfg_wl_floor;
      sel_pw            = cfg_pulse_cyc;
    end else begin
      sel_rng = builtin_range(op_e'(op));
      sel_pw  = PW_DEF;
    end
  end

  rps_search #(.CODE_W(CODE_W)) u_search (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .advance   (step),
    .wl_first  (sel_rng.wl_first),
    .wl_last   (sel_rng.wl_last),
    .drv_first (sel_rng.drv_first),
    .drv_last  (sel_rng.drv_last),
    .wl_lvl    (wl_lvl),
    .drv_lvl   (drv_lvl),
    .exhausted (exhausted)
  );

  rps_timer #(.PW_W(PW_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (st_q == S_SETUP),
    .run   (st_q == S_PULSE),
    .width (pw_q),
    .last  (t_last)
  );

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (start_ok) st_d = S_SETUP;
      S_SETUP: st_d = S_PULSE;
      S_PULSE: if (t_last) st_d = S_POST;
      S_POST:  st_d = S_VFY;
      S_VFY: begin
        if (vfy_valid) begin
          if (vfy_pass || exhausted) st_d = S_DONE;
          else                       st_d = S_SETUP;
        end
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_FORM;
      floor_q <= '0;
      pw_q    <= '0;
      pass_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q <= st_d;
      if (start_ok) begin
        op_q    <= op_e'(op);
        floor_q <= sel_rng.wl_floor;
        pw_q    <= sel_pw;
      end
      if (start_ok)
        pass_q <= 1'b0;
      else if ((st_q == S_VFY) && vfy_valid)
        pass_q <= vfy_pass;
      if (start_ok)
        cnt_q <= '0;
      else if (st_q == S_SETUP)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active = (st_q == S_SETUP) || (st_q == S_PULSE) ||
                  (st_q == S_POST)  || (st_q == S_VFY);
  assign wl_eff = (wl_lvl < floor_q) ? floor_q : wl_lvl;

  assign wl_code   = active ? wl_eff : '0;
  assign bl_code   = (active && (op_q != OP_RESET)) ? drv_lvl : '0;
  assign sl_code   = (active && (op_q == OP_RESET)) ? drv_lvl : '0;
  assign pulse_en  = (st_q == S_PULSE);
  assign vfy_req   = (st_q == S_VFY);
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_DONE);
  assign pass      = pass_q;
  assign pulse_cnt = cnt_q;

  // R6: codes hold steady for the whole pulse, including its first cycle
  p_codes_stable_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |-> ($stable(wl_code) && $stable(bl_code) && $stable(sl_code)));

  // R6: the cycle after a pulse keeps the codes and does not yet verify
  p_settle_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_en) |-> ($stable(wl_code) && $stable(bl_code) && !vfy_req));

  // R2: never both lines driven at once
  p_one_line_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !((bl_code != '0) && (sl_code != '0)));

  // R9: wordline stays at or above the floor while pulsing
  p_wl_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_en |-> (wl_code >= floor_q));

  // R8: lines are released when the operation completes
  p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((wl_code == '0) && (bl_code == '0) && (sl_code == '0)));

  // R10: the captured operation cannot change while busy
  p_op_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(op_q));

  // R7: done is a single-cycle strobe
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/rram_pulse_seq_tb.sv
`timescale 1ns/1ps
module rram_pulse_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic        use_cfg;
  logic [5:0]  cfg_wl_first, cfg_wl_last, cfg_drv_first, cfg_drv_last, cfg_wl_floor;
  logic [15:0] cfg_pulse_cyc;
  logic        vfy_valid, vfy_pass;
  logic [5:0]  wl_code, bl_code, sl_code;
  logic        pulse_en, vfy_req, busy, done, pass;
  logic [12:0] pulse_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // monitor state
  int mon_pulses = 0;
  int cur_len = 0;
  int last_len = 0;
  int req_len = 0;
  int last_req_len = 0;
  int rec_wl[16];
  int rec_bl[16];
  int rec_sl[16];
  logic [5:0] p_wl, p_bl, p_sl;
  logic       p_pen = 1'b0;
  logic       p_req = 1'b0;

  // responder settings
  int pass_at = 0;
  int vfy_delay = 0;
  int req_seen = 0;

  int res_pass, res_cnt;

  always #2.5 clk = ~clk;

  rram_pulse_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .use_cfg(use_cfg),
    .cfg_wl_first(cfg_wl_first), .cfg_wl_last(cfg_wl_last),
    .cfg_drv_first(cfg_drv_first), .cfg_drv_last(cfg_drv_last),
    .cfg_wl_floor(cfg_wl_floor), .cfg_pulse_cyc(cfg_pulse_cyc),
    .vfy_valid(vfy_valid), .vfy_pass(vfy_pass),
    .wl_code(wl_code), .bl_code(bl_code), .sl_code(sl_code),
    .pulse_en(pulse_en), .vfy_req(vfy_req), .busy(busy), .done(done),
    .pass(pass), .pulse_cnt(pulse_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pulse and verify monitor (R6 settle checks run on every pulse)
  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse_en && !p_pen) begin
        if (mon_pulses < 16) begin
          rec_wl[mon_pulses] = int'(wl_code);
          rec_bl[mon_pulses] = int'(bl_code);
          rec_sl[mon_pulses] = int'(sl_code);
        end
        mon_pulses++;
        chk(p_wl == wl_code && p_bl == bl_code && p_sl == sl_code,
            "R6 pre-settle", int'(p_wl), int'(wl_code));
      end
      if (pulse_en) cur_len++;
      if (!pulse_en && p_pen) begin
        last_len = cur_len;
        cur_len = 0;
        chk(p_wl == wl_code && p_bl == bl_code && !vfy_req,
            "R6 post-settle", int'(vfy_req), 0);
      end
      if (vfy_req) req_len++;
      if (!vfy_req && p_req) begin
        last_req_len = req_len;
        req_len = 0;
      end
    end
    p_wl = wl_code; p_bl = bl_code; p_sl = sl_code;
    p_pen = pulse_en; p_req = vfy_req;
  end

  // verify responder
  always @(negedge clk) begin
    if (vfy_valid) begin
      vfy_valid = 1'b0;
      vfy_pass  = 1'b0;
      req_seen  = 0;
    end else if (vfy_req) begin
      if (req_seen >= vfy_delay) begin
        vfy_valid = 1'b1;
        vfy_pass  = (pass_at != 0) && (mon_pulses == pass_at);
      end else begin
        req_seen++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic run_op(input logic [1:0] o, input logic uc,
                        input int wf, input int wlast, input int df, input int dl,
                        input int fl, input int pw, input int pa, input int dly);
    int guard;
    @(negedge clk);
    op = o; use_cfg = uc;
    cfg_wl_first = 6'(wf); cfg_wl_last = 6'(wlast);
    cfg_drv_first = 6'(df); cfg_drv_last = 6'(dl);
    cfg_wl_floor = 6'(fl); cfg_pulse_cyc = 16'(pw);
    pass_at = pa; vfy_delay = dly; mon_pulses = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    res_pass = int'(pass);
    res_cnt  = int'(pulse_cnt);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; op = 2'b00; use_cfg = 1'b0;
    cfg_wl_first = '0; cfg_wl_last = '0; cfg_drv_first = '0; cfg_drv_last = '0;
    cfg_wl_floor = '0; cfg_pulse_cyc = '0; vfy_valid = 1'b0; vfy_pass = 1'b0;
    repeat (3) @(negedge clk);
    chk(wl_code == 0 && bl_code == 0 && sl_code == 0, "R1 codes in reset", int'(wl_code), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!pulse_en && !vfy_req && !busy && !done, "R1 idle flags", int'(busy), 0);
  endtask

  task automatic t_set_default;
    run_op(2'b01, 1'b0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk(rec_wl[0] == 17, "R3 set wl", rec_wl[0], 17);
    chk(rec_bl[0] == 24 && rec_sl[0] == 0, "R2 set drives bl", rec_bl[0], 24);
    chk(last_len == 200, "R3 default width", last_len, 200);
    chk(res_pass == 1 && res_cnt == 1, "R7 set pass count", res_cnt, 1);
    chk(wl_code == 0 && bl_code == 0 && !busy, "R1 idle after op", int'(wl_code), 0);
  endtask

  task automatic t_reset_default;
    run_op(2'b10, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk(rec_sl[0] == 26 && rec_bl[0] == 0, "R2 reset drives sl", rec_sl[0], 26);
    chk(rec_wl[0] == 25, "R3 reset wl", rec_wl[0], 25);
    chk(res_pass == 0 && res_cnt == 1, "R8 single point fail", res_cnt, 1);
  endtask

  task automatic t_search;
    int exp_wl[5] = '{3, 4, 5, 3, 4};
    int exp_bl[5] = '{10, 10, 10, 11, 11};
    run_op(2'b00, 1'b1, 3, 5, 10, 11, 0, 4, 5, 3);
    for (int i = 0; i < 5; i++) begin
      chk(rec_wl[i] == exp_wl[i], "R4 inner wl step", rec_wl[i], exp_wl[i]);
      chk(rec_bl[i] == exp_bl[i] && rec_sl[i] == 0, "R4 outer bl step", rec_bl[i], exp_bl[i]);
    end
    chk(last_len == 4, "R5 width 4", last_len, 4);
    chk(last_req_len == 4, "R7 req held until valid", last_req_len, 4);
    chk(res_pass == 1 && res_cnt == 5, "R7 pass on fifth", res_cnt, 5);
  endtask

  task automatic t_form_default;
    run_op(2'b00, 1'b0, 0, 0, 0, 0, 0, 0, 13, 0);
    chk(rec_wl[0] == 14 && rec_bl[0] == 24, "R3 form start", rec_wl[0], 14);
    chk(rec_wl[11] == 25 && rec_bl[11] == 24, "R3 form wl top", rec_wl[11], 25);
    chk(rec_wl[12] == 14 && rec_bl[12] == 25, "R4 form wrap", rec_bl[12], 25);
    chk(res_pass == 1 && res_cnt == 13, "R7 form count", res_cnt, 13);
  endtask

  task automatic t_exhaust;
    int exp_sl[4] = '{20, 20, 21, 21};
    run_op(2'b10, 1'b1, 7, 8, 20, 21, 0, 2, 0, 0);
    for (int i = 0; i < 4; i++)
      chk(rec_sl[i] == exp_sl[i] && rec_bl[i] == 0, "R8 reset sweep", rec_sl[i], exp_sl[i]);
    chk(last_len == 2, "R5 width 2", last_len, 2);
    chk(res_pass == 0 && res_cnt == 4, "R8 exhausted count", res_cnt, 4);
    chk(wl_code == 0 && sl_code == 0 && bl_code == 0 && !busy, "R8 codes released", int'(sl_code), 0);
  endtask

  task automatic t_floor;
    run_op(2'b01, 1'b1, 1, 2, 5, 5, 4, 1, 0, 0);
    chk(rec_wl[0] == 4 && rec_wl[1] == 4, "R9 floor clamp", rec_wl[1], 4);
    chk(last_len == 1, "R5 width 1", last_len, 1);
    chk(res_cnt == 2, "R8 two pulses", res_cnt, 2);
    run_op(2'b01, 1'b1, 6, 6, 5, 5, 4, 0, 1, 0);
    chk(rec_wl[0] == 6, "R9 above floor", rec_wl[0], 6);
    chk(last_len == 1, "R5 width 0 as 1", last_len, 1);
  endtask

  task automatic t_ignore;
    int guard;
    @(negedge clk);
    op = 2'b01; use_cfg = 1'b1;
    cfg_wl_first = 6'd9; cfg_wl_last = 6'd12; cfg_drv_first = 6'd7; cfg_drv_last = 6'd7;
    cfg_wl_floor = 6'd0; cfg_pulse_cyc = 16'd20;
    pass_at = 2; vfy_delay = 0; mon_pulses = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    op = 2'b10; cfg_drv_first = 6'd30; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    res_cnt = int'(pulse_cnt);
    chk(rec_sl[0] == 0 && rec_sl[1] == 0 && rec_bl[1] == 7, "R10 busy start ignored", rec_bl[1], 7);
    chk(res_cnt == 2, "R10 count unchanged", res_cnt, 2);
    @(negedge clk);
    op = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && wl_code == 0 && !pulse_en, "R10 op 11 ignored", int'(busy), 0);
  endtask

  initial begin
    t_reset();
    t_set_default();
    t_reset_default();
    t_search();
    t_form_default();
    t_exhaust();
    t_floor();
    t_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule